// File: doc/BRIEF.md
# Reconfiguration Latency Statistics Recorder

This block watches a reconfiguration handshake made of a request pulse and a completion pulse. For each request it counts the clock cycles until the matching completion. It stores every result as a 32-bit unsigned word in an on-chip sample memory. Results go into consecutive slots starting at slot 0. When the last slot has been written, recording stops until a clear pulse arms it again. A host reads the memory back through a plain synchronous read port, which stands in for a memory-mapped bus slave. The host also reads a write pointer that holds the number of stored samples. A free-running 32-bit cycle stamp on the same clock lets the host place the captured samples in time.

The measurement is controlled by a three-state machine. The states are `ST_IDLE` (waiting for a request), `ST_MEASURE` (counting) and `ST_HALT` (memory full). The transitions are:
- `ST_IDLE` to `ST_MEASURE` when a request arrives.
- `ST_MEASURE` to `ST_MEASURE` when a request arrives during a measurement. This restarts the count.
- `ST_MEASURE` to `ST_IDLE` when a completion stores a sample and free slots remain.
- `ST_MEASURE` to `ST_HALT` when a completion fills the last slot.
- Any state to `ST_IDLE` on clear.

The memory depth is 2^ADDR_W words. The default of 10 keeps elaboration small, and setting ADDR_W to 16 gives a buffer of 65,536 samples (256 KB).

Top module: `lat_stats_recorder`

## Requirements
- R1: After reset, `wr_count` is 0, `buf_full` is 0 and `cycle_stamp` is 0.
- R2: `cycle_stamp` increases by exactly one on every clock edge after reset.
- R3: If a request is sampled at edge E and a completion is sampled at edge E+L, the stored sample is L (for L from 1 up to the saturation value).
- R4: The interval counter is CNT_W bits wide and saturates at all-ones. A longer interval stores 2^CNT_W-1, zero-extended into the 32-bit word.
- R5: A completion sampled while no measurement is running writes nothing and leaves `wr_count` unchanged.
- R6: A request sampled during a measurement restarts the count from that edge. If a request and a completion are sampled at the same edge, the request wins and nothing is written.
- R7: Samples go to addresses 0, 1, 2, … in arrival order, and `wr_count` holds the number of samples stored.
- R8: `buf_full` rises in the cycle after slot 2^ADDR_W-1 is written, and `wr_count` then equals 2^ADDR_W. Afterwards, requests and completions write nothing until a clear.
- R9: A clear pulse sets `wr_count` and `buf_full` to 0 and aborts any measurement in progress. It leaves the memory contents unchanged, and new samples overwrite the memory from address 0.
- R10: `rd_data` shows the memory word at the `rd_addr` value sampled on the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Re-arm recording: empty pointer and full flag |
| rcfg_req | input | 1 | Reconfiguration request pulse |
| rcfg_done | input | 1 | Reconfiguration completion pulse |
| rd_addr | input | ADDR_W | Sample memory read address |
| rd_data | output | 32 | Registered read data |
| wr_count | output | ADDR_W+1 | Number of stored samples |
| buf_full | output | 1 | Sample memory full |
| cycle_stamp | output | STAMP_W | Free-running cycle stamp |

## Verification
The hardest situation to reach from the ports is the saturated interval: with a 32-bit counter it would need billions of idle cycles. The bench therefore builds the recorder with a 5-bit counter and an 8-slot memory. In that configuration, a 40-cycle wait saturates the counter, and eight completions fill the memory. This lets the fill, halt and clear sequence run end to end. Restart, same-edge request and completion, and clear during a measurement are each created by driving the two handshake pulses with exact edge offsets. The bench then reads the memory back to compare against the arithmetic expectations.

// File: rtl/lat_pkg.sv
package lat_pkg;
    localparam int SAMPLE_W = 32;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_MEASURE = 2'd1,
        ST_HALT    = 2'd2
    } meas_state_t;
endpackage

// File: rtl/lat_cycle_stamp.sv
module lat_cycle_stamp #(
    parameter int STAMP_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [STAMP_W-1:0] stamp
);
    always_ff @(posedge clk) begin
        if (!rst_n) stamp <= '0;
        else        stamp <= stamp + 1'b1;
    end

    AST_STAMP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (stamp == $past(stamp) + 1'b1)); // R2
endmodule

// File: rtl/lat_interval_fsm.sv
module lat_interval_fsm
    import lat_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             req,
    input  logic             done,
    input  logic             last_slot,
    output logic             wr_en,
    output logic [CNT_W-1:0] interval
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    meas_state_t state, state_nx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        if (clr) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:    if (req) state_nx = ST_MEASURE;
                ST_MEASURE: begin
                    if (req)       state_nx = ST_MEASURE;
                    else if (done) state_nx = last_slot ? ST_HALT : ST_IDLE;
                end
                ST_HALT:    state_nx = ST_HALT;
                default:    state_nx = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        wr_en = 1'b0;
        unique case (state)
            ST_MEASURE: wr_en = done && !req && !clr;
            default:    wr_en = 1'b0;
        endcase
    end

    // interval counter
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            interval <= '0;
        end else if (req && state != ST_HALT) begin
            interval <= {{(CNT_W-1){1'b0}}, 1'b1};
        end else if (state == ST_MEASURE && interval != CNT_MAX) begin
            interval <= interval + 1'b1;
        end
    end

    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MEASURE && interval == CNT_MAX && !req && !clr) |=> (interval == CNT_MAX)); // R4
    AST_RESTART_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !clr && state != ST_HALT) |=> (interval == 1 && state == ST_MEASURE)); // R6
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT && !clr) |=> (state == ST_HALT)); // R8
    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_MEASURE) |-> !wr_en); // R5
endmodule

// File: rtl/lat_sample_store.sv
module lat_sample_store
    import lat_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int CNT_W  = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                wr_en,
    input  logic [CNT_W-1:0]    wr_val,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [SAMPLE_W-1:0] rd_data,
    output logic [ADDR_W:0]     wr_count,
    output logic                full,
    output logic                last_slot
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W:0] DEPTH_V = (ADDR_W+1)'(DEPTH);
    localparam logic [ADDR_W:0] LAST_V  = (ADDR_W+1)'(DEPTH - 1);

    logic [SAMPLE_W-1:0] mem [DEPTH];

    assign full      = (wr_count == DEPTH_V);
    assign last_slot = (wr_count == LAST_V);

    always_ff @(posedge clk) begin
        if (!rst_n || clr)               wr_count <= '0;
        else if (wr_en && !full)         wr_count <= wr_count + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (wr_en && !full) mem[wr_count[ADDR_W-1:0]] <= SAMPLE_W'(wr_val);
    end

    always_ff @(posedge clk) begin
        rd_data <= mem[rd_addr];
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !full); // R8
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr) |=> (wr_count == $past(wr_count) + 1'b1)); // R7
    AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (wr_count == 0 && !full)); // R9
    AST_PTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        wr_count <= DEPTH_V); // R8
endmodule

// File: rtl/lat_stats_recorder.sv
module lat_stats_recorder
    import lat_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int CNT_W   = 32,
    parameter int STAMP_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                rcfg_req,
    input  logic                rcfg_done,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [SAMPLE_W-1:0] rd_data,
    output logic [ADDR_W:0]     wr_count,
    output logic                buf_full,
    output logic [STAMP_W-1:0]  cycle_stamp
);
    logic             wr_en;
    logic             last_slot;
    logic [CNT_W-1:0] interval;

    lat_interval_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .req       (rcfg_req),
        .done      (rcfg_done),
        .last_slot (last_slot),
        .wr_en     (wr_en),
        .interval  (interval)
    );

    lat_sample_store #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .wr_en     (wr_en),
        .wr_val    (interval),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .wr_count  (wr_count),
        .full      (buf_full),
        .last_slot (last_slot)
    );

    lat_cycle_stamp #(.STAMP_W(STAMP_W)) u_stamp (
        .clk   (clk),
        .rst_n (rst_n),
        .stamp (cycle_stamp)
    );
endmodule

// File: tb/tb_lat_stats_recorder.sv
module tb_lat_stats_recorder;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 3;
    localparam int CNT_W  = 5;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int SAT    = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0;
    logic rcfg_req = 1'b0;
    logic rcfg_done = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic [ADDR_W:0] wr_count;
    logic buf_full;
    logic [31:0] cycle_stamp;

    int total = 0;
    int bad = 0;
    int expv [DEPTH];

    always #(CLK_PERIOD/2) clk = ~clk;

    lat_stats_recorder #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .STAMP_W(32)) dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .rcfg_req(rcfg_req),
        .rcfg_done(rcfg_done), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_count(wr_count), .buf_full(buf_full), .cycle_stamp(cycle_stamp)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // request sampled at edge E, completion at edge E+len
    task automatic measure(input int len);
        @(negedge clk) rcfg_req = 1'b1;
        @(negedge clk) rcfg_req = 1'b0;
        repeat (len - 1) @(negedge clk);
        rcfg_done = 1'b1;
        @(negedge clk) rcfg_done = 1'b0;
    endtask

    task automatic pulse_req();
        @(negedge clk) rcfg_req = 1'b1;
        @(negedge clk) rcfg_req = 1'b0;
    endtask

    task automatic read_word(input int a, output int v);
        @(negedge clk) rd_addr = ADDR_W'(a);
        @(negedge clk) v = int'(rd_data);
    endtask

    initial begin
        int v;
        longint s0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // first edge after release happens before this negedge
        @(negedge clk);
        check(wr_count == 0 && !buf_full, "R1 empty after reset", wr_count, 0);
        check(cycle_stamp == 1, "R1 stamp from zero", cycle_stamp, 1);

        s0 = cycle_stamp;
        repeat (7) @(negedge clk);
        check(cycle_stamp == s0 + 7, "R2 stamp step", cycle_stamp, s0 + 7);

        // stray completion
        @(negedge clk) rcfg_done = 1'b1;
        @(negedge clk) rcfg_done = 1'b0;
        check(wr_count == 0, "R5 stray done ignored", wr_count, 0);

        // plain intervals
        expv[0] = 1; measure(1);
        expv[1] = 2; measure(2);
        expv[2] = 3; measure(3);
        check(wr_count == 3, "R7 count after three", wr_count, 3);

        // restart mid-measurement
        pulse_req();
        repeat (3) @(negedge clk);
        expv[3] = 4; measure(4);
        check(wr_count == 4, "R6 restart single write", wr_count, 4);

        // request and completion together during a measurement
        pulse_req();
        @(negedge clk);
        rcfg_req = 1'b1; rcfg_done = 1'b1;
        @(negedge clk);
        rcfg_req = 1'b0; rcfg_done = 1'b0;
        check(wr_count == 4, "R6 same-edge no write", wr_count, 4);
        repeat (4) @(negedge clk);
        rcfg_done = 1'b1;
        @(negedge clk) rcfg_done = 1'b0;
        expv[4] = 5;
        check(wr_count == 5, "R6 restart then done", wr_count, 5);

        // saturation
        expv[5] = SAT; measure(40);
        expv[6] = 7;   measure(7);
        check(!buf_full && wr_count == 7, "R8 not full before last", wr_count, 7);
        expv[7] = SAT; measure(SAT);
        check(buf_full && wr_count == DEPTH, "R8 full after last", wr_count, DEPTH);

        measure(2);
        check(buf_full && wr_count == DEPTH, "R8 ignored when full", wr_count, DEPTH);

        for (int i = 0; i < DEPTH; i++) begin
            read_word(i, v);
            check(v == expv[i], $sformatf("R3 R4 R7 R10 slot %0d", i), v, expv[i]);
        end

        // clear keeps contents
        @(negedge clk) clr = 1'b1;
        @(negedge clk) clr = 1'b0;
        check(!buf_full && wr_count == 0, "R9 clear empties", wr_count, 0);
        read_word(0, v);
        check(v == expv[0], "R9 contents kept", v, expv[0]);

        // clear during a measurement aborts it
        pulse_req();
        @(negedge clk) clr = 1'b1;
        @(negedge clk) clr = 1'b0;
        @(negedge clk) rcfg_done = 1'b1;
        @(negedge clk) rcfg_done = 1'b0;
        check(wr_count == 0, "R9 clear aborts", wr_count, 0);

        measure(6);
        read_word(0, v);
        check(v == 6, "R9 overwrite slot 0", v, 6);
        read_word(1, v);
        check(v == expv[1], "R9 slot 1 untouched", v, expv[1]);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 5000, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule